// File: doc/BRIEF.md
# Flash Byte/Word Host Bus Interface

This block is the host-facing pin front end of a NOR-style flash memory model. Every clock it looks at the chip-select, output-enable, write-enable, reset and byte/word mode pins and classifies the bus as one of six operations. From that it decides whether the 16-bit data bus is driven with read data or left floating. The tristate bus is modelled as a data-out vector with a per-bit enable, so the block stays synthesizable.

The block gives the internal core a decoded 20-bit address and a read-active flag, and it takes the read word back from the core. When a write cycle ends, it hands the core a one-cycle write strobe. The strobe carries the address and data held in the last clock of that write.

In byte mode the top data pin stops being data. It becomes the lowest address bit, and only the low eight data pins move data. The same pin therefore switches between address input and data lane depending on the mode pin.

Top module: `flash_bus_if`

## Requirements
- R1: `busOp` reports the pin decode with these codes: 0 when reset is low, whatever the other pins do. Otherwise 1 when chip-select is high. Otherwise, with chip-select low: 2 for output-enable low and write-enable high, 3 for write-enable low and output-enable high, 4 for both high, and 5 for both low.
- R2: During a read (code 2) in word mode, `dataOutEn` is 16'hFFFF and `dataOut` equals `rdData`.
- R3: During a write (code 3), `dataOutEn` is all zero.
- R4: While reset is low, `dataOutEn` is zero and `wrStrobe` is low. A write that is cut short by reset produces no strobe.
- R5: In the clock after the last clock of a write, `wrStrobe` is high for exactly one cycle. `wrAddr` and `wrData` then hold the values sampled in that last write clock. This applies whether write-enable or chip-select ends the write.
- R6: During a read in byte mode (byte pin low), `dataOutEn` is 16'h00FF, so pins 15:8 float.
- R7: In standby, output-disable and conflict (codes 1, 4, 5), `dataOutEn` is all zero.
- R8: `coreAddr` is {addrIn, 1'b0} in word mode and {addrIn, dataIn[15]} in byte mode.
- R9: During a byte-mode read, `dataOut[7:0]` is `rdData[15:8]` when dataIn[15] is 1 and `rdData[7:0]` when it is 0, and `dataOut[15:8]` is zero.
- R10: Write data is `dataIn` in word mode and {8'h00, dataIn[7:0]} in byte mode. The write address follows R8.
- R11: `coreRead` is high exactly when the operation is a read (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| pinRstN | input | 1 | Reset pin, active low, also clears the write capture state |
| pinCsN | input | 1 | Chip select, active low |
| pinOeN | input | 1 | Output enable, active low |
| pinWeN | input | 1 | Write enable, active low |
| pinByteN | input | 1 | Mode pin: high selects word mode, low selects byte mode |
| addrIn | input | 19 | Address pins |
| dataIn | input | 16 | Data pins as seen at the input side; bit 15 is the extra address bit in byte mode |
| rdData | input | 16 | Word returned by the internal core |
| dataOut | output | 16 | Value driven onto the data pins |
| dataOutEn | output | 16 | Per-pin drive enable; 0 means the pin floats |
| busOp | output | 3 | Decoded bus operation code |
| coreRead | output | 1 | Read operation active |
| coreAddr | output | 20 | Decoded internal address |
| wrStrobe | output | 1 | One-cycle write strobe to the command engine |
| wrAddr | output | 20 | Address captured for the write strobe |
| wrData | output | 16 | Data captured for the write strobe |

## Verification
The hardest situations to reach from the ports are writes that do not end cleanly: a write closed by chip-select rising while write-enable stays low, and a write cut off by reset before it can fire. Random stimulus is biased toward chip-select low and reset high, so write operations often stand next to other operations. Directed sequences then force both awkward endings and a byte-mode write whose address bit arrives on data pin 15. A bench model tracks the write-capture state clock by clock and predicts the strobe, address and data.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  typedef enum logic [2:0] {
    OP_RESET    = 3'd0,
    OP_STANDBY  = 3'd1,
    OP_READ     = 3'd2,
    OP_WRITE    = 3'd3,
    OP_OUTDIS   = 3'd4,
    OP_CONFLICT = 3'd5
  } busOp_e;

  typedef struct packed {
    logic driveRead;     // read operation: put core data on the pins
    logic captureWrite;  // write operation: sample address and data
    logic fireWrite;     // write has just ended: issue the strobe
    logic byteMode;      // byte pin low
  } busStrobe_t;

endpackage

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
(
  input  logic       clk,
  input  logic       pinRstN,
  input  logic       pinCsN,
  input  logic       pinOeN,
  input  logic       pinWeN,
  input  logic       pinByteN,
  output busOp_e     busOp,
  output busStrobe_t strobe
);

  logic wrActPrev;
  logic wrActNow;

  // Operation decode: reset first, then chip select, then the enable pair.
  always_comb begin
    if (!pinRstN)                busOp = OP_RESET;
    else if (pinCsN)             busOp = OP_STANDBY;
    else if (!pinOeN && pinWeN)  busOp = OP_READ;
    else if (pinOeN && !pinWeN)  busOp = OP_WRITE;
    else if (pinOeN && pinWeN)   busOp = OP_OUTDIS;
    else                         busOp = OP_CONFLICT;
  end

  assign wrActNow = (busOp == OP_WRITE);

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN) wrActPrev <= 1'b0;
    else          wrActPrev <= wrActNow;
  end

  always_comb begin
    strobe.driveRead    = (busOp == OP_READ);
    strobe.captureWrite = wrActNow;
    strobe.fireWrite    = wrActPrev && !wrActNow && pinRstN;
    strobe.byteMode     = !pinByteN;
  end

  // R1: a conflict decode always has both enables low
  assert_conflict_pins_R1: assert property (@(posedge clk) disable iff (!pinRstN)
    (busOp == OP_CONFLICT) |-> (!pinCsN && !pinOeN && !pinWeN));

  // R5: a fire request always follows a sampled write clock
  assert_fire_follows_write_R5: assert property (@(posedge clk) disable iff (!pinRstN)
    strobe.fireWrite |-> $past(busOp) == OP_WRITE);

endmodule

// File: rtl/flash_bus_dp.sv
module flash_bus_dp
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                pinRstN,
  input  busStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   dataOut,
  output logic [DATA_W-1:0]   dataOutEn,
  output logic [ADDR_W:0]     coreAddr,
  output logic                wrStrobe,
  output logic [ADDR_W:0]     wrAddr,
  output logic [DATA_W-1:0]   wrData
);

  localparam int BYTE_W  = DATA_W / 2;
  localparam int LANES   = DATA_W / BYTE_W;
  localparam int CADDR_W = ADDR_W + 1;

  logic                lowAddrBit;
  logic [DATA_W-1:0]   wrDataNow;
  logic [CADDR_W-1:0]  latAddr;
  logic [DATA_W-1:0]   latData;
  logic [BYTE_W-1:0]   byteSel;

  // In byte mode the top data pin carries the lowest address bit.
  assign lowAddrBit = strobe.byteMode ? dataIn[DATA_W-1] : 1'b0;
  assign coreAddr   = {addrIn, lowAddrBit};

  assign wrDataNow = strobe.byteMode ? {{(DATA_W-BYTE_W){1'b0}}, dataIn[BYTE_W-1:0]}
                                     : dataIn;

  assign byteSel = lowAddrBit ? rdData[DATA_W-1:DATA_W-BYTE_W] : rdData[BYTE_W-1:0];

  always_comb begin
    if (strobe.byteMode) dataOut = {{(DATA_W-BYTE_W){1'b0}}, byteSel};
    else                 dataOut = rdData;
  end

  // Per-lane drive enables: lane 0 follows the read, upper lanes only in word mode.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    if (ln == 0) begin : g_low
      assign dataOutEn[BYTE_W-1:0] = {BYTE_W{strobe.driveRead}};
    end else begin : g_high
      assign dataOutEn[ln*BYTE_W +: BYTE_W] = {BYTE_W{strobe.driveRead && !strobe.byteMode}};
    end
  end

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN) begin
      latAddr  <= '0;
      latData  <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      if (strobe.captureWrite) begin
        latAddr <= coreAddr;
        latData <= wrDataNow;
      end
      wrStrobe <= strobe.fireWrite;
      if (strobe.fireWrite) begin
        wrAddr <= latAddr;
        wrData <= latData;
      end
    end
  end

  // R5: the strobe is never longer than one clock
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!pinRstN)
    wrStrobe |=> !wrStrobe);

  // R6: byte mode never drives the upper lanes
  assert_upper_float_R6: assert property (@(posedge clk) disable iff (!pinRstN)
    strobe.byteMode |-> (dataOutEn[DATA_W-1:BYTE_W] == '0));

  // R9: byte-mode read data keeps its upper half clear
  assert_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (!pinRstN)
    (strobe.byteMode && strobe.driveRead) |-> (dataOut[DATA_W-1:BYTE_W] == '0));

endmodule

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                pinRstN,
  input  logic                pinCsN,
  input  logic                pinOeN,
  input  logic                pinWeN,
  input  logic                pinByteN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   dataOut,
  output logic [DATA_W-1:0]   dataOutEn,
  output logic [2:0]          busOp,
  output logic                coreRead,
  output logic [ADDR_W:0]     coreAddr,
  output logic                wrStrobe,
  output logic [ADDR_W:0]     wrAddr,
  output logic [DATA_W-1:0]   wrData
);

  busOp_e     opDec;
  busStrobe_t strobe;

  flash_bus_ctrl u_ctrl (
    .clk      (clk),
    .pinRstN  (pinRstN),
    .pinCsN   (pinCsN),
    .pinOeN   (pinOeN),
    .pinWeN   (pinWeN),
    .pinByteN (pinByteN),
    .busOp    (opDec),
    .strobe   (strobe)
  );

  flash_bus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .pinRstN   (pinRstN),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .rdData    (rdData),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn),
    .coreAddr  (coreAddr),
    .wrStrobe  (wrStrobe),
    .wrAddr    (wrAddr),
    .wrData    (wrData)
  );

  assign busOp    = opDec;
  assign coreRead = strobe.driveRead;

  // R4: reset floats every pin
  always_comb begin
    if (!pinRstN) assert_reset_float_R4: assert (dataOutEn == '0);
  end

  // R3: nothing is driven while the host writes
  assert_write_float_R3: assert property (@(posedge clk) disable iff (!pinRstN)
    (!pinCsN && !pinWeN) |-> (dataOutEn == '0));

  // R7: standby floats the bus
  assert_standby_float_R7: assert property (@(posedge clk) disable iff (!pinRstN)
    pinCsN |-> (dataOutEn == '0));

  // R5: a strobe is seen two clocks after a sampled write clock
  assert_strobe_origin_R5: assert property (@(posedge clk) disable iff (!pinRstN)
    wrStrobe |-> ($past(busOp, 2) == 3'd3));

endmodule

// File: tb/flash_bus_if_tb.sv
module flash_bus_if_tb;

  logic        clk = 1'b0;
  logic        pinRstN = 1'b0, pinCsN = 1'b1, pinOeN = 1'b1, pinWeN = 1'b1, pinByteN = 1'b1;
  logic [18:0] addrIn = '0;
  logic [15:0] dataIn = '0, rdData = '0;
  logic [15:0] dataOut, dataOutEn, wrData;
  logic [2:0]  busOp;
  logic        coreRead, wrStrobe;
  logic [19:0] coreAddr, wrAddr;

  int checks = 0;
  int errors = 0;

  // Bench model of the write capture state
  logic        mPrev = 0, mStrobe = 0;
  logic [19:0] mLatA = '0, mAddr = '0;
  logic [15:0] mLatD = '0, mData = '0;

  always #5 clk = ~clk;

  flash_bus_if u_dut (
    .clk(clk), .pinRstN(pinRstN), .pinCsN(pinCsN), .pinOeN(pinOeN), .pinWeN(pinWeN),
    .pinByteN(pinByteN), .addrIn(addrIn), .dataIn(dataIn), .rdData(rdData),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .busOp(busOp), .coreRead(coreRead),
    .coreAddr(coreAddr), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic logic [2:0] expOp(logic r, logic c, logic o, logic w);
    if (!r) return 3'd0;
    if (c) return 3'd1;
    if (!o && w) return 3'd2;
    if (o && !w) return 3'd3;
    if (o && w) return 3'd4;
    return 3'd5;
  endfunction

  function automatic logic [19:0] expAddr(logic b, logic [18:0] a, logic [15:0] d);
    return b ? {a, 1'b0} : {a, d[15]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one clock: update model with the inputs sampled at the last
  // rising edge, check registered outputs, drive new pins, check decode.
  task automatic step(logic r, logic c, logic o, logic w, logic b,
                      logic [18:0] a, logic [15:0] d, logic [15:0] rd);
    logic [2:0] op;
    logic       act;
    @(negedge clk);
    if (!pinRstN) begin
      mPrev = 0; mStrobe = 0; mLatA = '0; mLatD = '0; mAddr = '0; mData = '0;
    end else begin
      act = (expOp(pinRstN, pinCsN, pinOeN, pinWeN) == 3'd3);
      mStrobe = mPrev && !act;
      if (mStrobe) begin mAddr = mLatA; mData = mLatD; end
      if (act) begin
        mLatA = expAddr(pinByteN, addrIn, dataIn);
        mLatD = pinByteN ? dataIn : {8'h00, dataIn[7:0]};
      end
      mPrev = act;
    end
    check("R4/R5 wrStrobe", {31'd0, wrStrobe}, {31'd0, mStrobe});
    if (mStrobe) begin
      check("R5/R8 wrAddr", {12'd0, wrAddr}, {12'd0, mAddr});
      check("R5/R10 wrData", {16'd0, wrData}, {16'd0, mData});
    end
    pinRstN = r; pinCsN = c; pinOeN = o; pinWeN = w; pinByteN = b;
    addrIn = a; dataIn = d; rdData = rd;
    #1;
    op = expOp(r, c, o, w);
    check("R1 busOp", {29'd0, busOp}, {29'd0, op});
    check("R11 coreRead", {31'd0, coreRead}, {31'd0, op == 3'd2});
    check("R8 coreAddr", {12'd0, coreAddr}, {12'd0, expAddr(b, a, d)});
    if (op == 3'd2 && b) begin
      check("R2 dataOutEn", {16'd0, dataOutEn}, 32'h0000FFFF);
      check("R2 dataOut", {16'd0, dataOut}, {16'd0, rd});
    end else if (op == 3'd2) begin
      check("R6 dataOutEn", {16'd0, dataOutEn}, 32'h000000FF);
      check("R9 dataOut", {16'd0, dataOut}, {24'd0, d[15] ? rd[15:8] : rd[7:0]});
    end else if (op == 3'd3) begin
      check("R3 dataOutEn", {16'd0, dataOutEn}, 32'd0);
    end else if (op == 3'd0) begin
      check("R4 dataOutEn", {16'd0, dataOutEn}, 32'd0);
    end else begin
      check("R7 dataOutEn", {16'd0, dataOutEn}, 32'd0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #1;
    // R4: reset state
    check("R4 reset dataOutEn", {16'd0, dataOutEn}, 32'd0);
    check("R1 reset busOp", {29'd0, busOp}, 32'd0);
    check("R4 reset wrStrobe", {31'd0, wrStrobe}, 32'd0);
    step(0, 0, 0, 1, 1, 19'h1, 16'h0, 16'hABCD);
    step(1, 1, 1, 1, 1, 19'h0, 16'h0, 16'h0);

    // R2: word read
    step(1, 0, 0, 1, 1, 19'h12345, 16'h0, 16'hBEEF);
    // R6, R9: byte reads, high and low halves
    step(1, 0, 0, 1, 0, 19'h00F00, 16'h8000, 16'hA55A);
    step(1, 0, 0, 1, 0, 19'h00F00, 16'h0000, 16'hA55A);
    // R5: word write ended by write-enable rising
    step(1, 0, 1, 0, 1, 19'h2AAAA, 16'h1111, 16'h0);
    step(1, 0, 1, 0, 1, 19'h55555, 16'h00A0, 16'h0);
    step(1, 0, 1, 1, 1, 19'h0, 16'h0, 16'h0);
    step(1, 1, 1, 1, 1, 19'h0, 16'h0, 16'h0);
    // R5, R10: byte write ended by chip-select rising, write-enable held low
    step(1, 0, 1, 0, 0, 19'h7FFFF, 16'h80C3, 16'h0);
    step(1, 1, 1, 0, 0, 19'h0, 16'h0, 16'h0);
    step(1, 1, 1, 1, 1, 19'h0, 16'h0, 16'h0);
    // R4: write cut by reset yields no strobe
    step(1, 0, 1, 0, 1, 19'h3, 16'h3333, 16'h0);
    step(0, 0, 1, 0, 1, 19'h3, 16'h3333, 16'h0);
    step(1, 1, 1, 1, 1, 19'h0, 16'h0, 16'h0);
    step(1, 1, 1, 1, 1, 19'h0, 16'h0, 16'h0);
    // R7: conflict and output disable
    step(1, 0, 0, 0, 1, 19'h1, 16'h0, 16'hFFFF);
    step(1, 0, 1, 1, 0, 19'h1, 16'h0, 16'hFFFF);

    // Random mix biased toward selected, out-of-reset cycles
    for (int i = 0; i < 3000; i++) begin
      logic r, c, o, w, b;
      r = ($urandom % 100) >= 4;
      c = ($urandom % 100) < 15;
      o = $urandom[0];
      w = $urandom[0];
      b = $urandom[0];
      step(r, c, o, w, b, 19'($urandom), 16'($urandom), 16'($urandom));
    end
    step(1, 1, 1, 1, 1, 19'h0, 16'h0, 16'h0);
    step(1, 1, 1, 1, 1, 19'h0, 16'h0, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule